// File: doc/BRIEF.md
# Escalating Key-Locked Watchdog

The block is a watchdog counter that, once started, walks through four timed stages in order. Every stage has its own timeout, counted in prescaled ticks, and its own expiry action. The action can do nothing, latch a level interrupt, or drive a pulse on the CPU reset or system reset output. Software keeps the chip alive by feeding the watchdog, which restarts stage 0 with an empty count. A typical setup has stage 0 raise the interrupt so a handler can recover. If the handler misses the next deadline, stage 1 pulls the CPU reset.

Every register except the lock register ignores writes unless the lock register holds a fixed 32-bit key. Software therefore unlocks, makes its changes and locks again. A prescaler divides the input clock into watchdog ticks. The two reset outputs have separately coded pulse lengths. After a reset pulse ends, the stage walk starts again from stage 0, so each missed deadline produces another reset.

Top module: `wdog_stage_timer`

## Requirements
- R1: Writes to any register other than the lock register (address 0x7) are ignored unless the lock register holds 0x5A17C0DE. Writing any other value there relocks the block. Reading address 0x7 returns 1 while the block is unlocked and 0 while it is locked.
- R2: The divider at address 0x1 produces one watchdog tick every P input cycles while counting. A value of 0 acts as 1.
- R3: Stage n (0 to 3) has a timeout at address 0x2+n and expires after that many ticks. A timeout of 0 acts as 1. After stage n expires with the interrupt action, stage n+1 starts with a cleared count.
- R4: Control register 0x0: bit 0 enable, bit 1 interrupt level enable, bits [3+2n:2+2n] action of stage n, bits [12:10] CPU reset length, bits [15:13] system reset length. Action codes: 0 none, 1 interrupt, 2 CPU reset, 3 system reset.
- R5: An expiry with the interrupt action latches a pending flag. irq_o equals the flag AND control bit 1 AND bit 0 of address 0x8. A write to address 0x9 clears the flag, and so does a feed.
- R6: A write to address 0x6 restarts the watchdog at stage 0 with a cleared tick count and a cleared prescaler.
- R7: Clearing the enable bit freezes the prescaler and the stage count. Setting it again resumes counting where it stopped.
- R8: An expiry with a reset action drives the matching output high for (code+1)*32 input cycles, where code is that output's length field. The two reset outputs are never high together.
- R9: One cycle after a reset pulse ends, stage 0 restarts with a cleared count. While the block stays enabled, each missed deadline produces another pulse.
- R10: When the current stage's action is none, the block halts in that stage and takes no further action until a feed or a 0-to-1 change of the enable bit.
- R11: Status at address 0xA: bit 0 is the pending interrupt flag, bits [2:1] are the current stage, and bits [4:3] are the state (0 counting, 1 halted, 2 waiting for a pulse to end).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A write takes effect at the clock edge where it is strobed, and read data follows the address within the same cycle. Count cycles from the edge that starts counting: this is either the enable write or the feed. The interrupt and a reset output then rise at the edge P times the summed timeouts later. After a reset pulse of L cycles, the next expiry comes L+1+T0*P cycles after the pulse rose. The bench keeps a free-running edge counter and drives inputs on falling edges. It records that counter at the falling edge after each start or freeze write and after each output change. It then compares the differences with values computed from the programmed P, T and length codes. The time spent disabled is added to the expected delay.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned NSTG   = 4;
  localparam int unsigned SW     = $clog2(NSTG);
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {ACT_OFF = 2'd0, ACT_IRQ = 2'd1, ACT_CPU = 2'd2, ACT_SYS = 2'd3} act_e;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_HOLD = 2'd1, ST_PULSE = 2'd2} st_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'h1;
  localparam logic [ADDR_W-1:0] A_TMO0  = 4'h2;
  localparam logic [ADDR_W-1:0] A_FEED  = 4'h6;
  localparam logic [ADDR_W-1:0] A_KEY   = 4'h7;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'h8;
  localparam logic [ADDR_W-1:0] A_ICLR  = 4'h9;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'hA;

  typedef struct packed {
    logic [2:0]        sys_len;
    logic [2:0]        cpu_len;
    logic [2*NSTG-1:0] act;
    logic              lvl_en;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter logic [31:0] KEY = 32'h5A17_C0DE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output ctrl_t                 ctrl_o,
  output logic [31:0]           presc_o,
  output logic [NSTG-1:0][31:0] tmo_o,
  output logic                  ien_o,
  output logic                  feed_o,
  output logic                  iclr_o,
  input  logic                  int_raw_i,
  input  logic [SW-1:0]         stage_i,
  input  logic [1:0]            state_i
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic [31:0] key_q, presc_q;
  ctrl_t       ctrl_q;
  logic        ien_q, unlocked, wr_ok;
  logic [NSTG-1:0][31:0] tmo_q;

  assign unlocked = (key_q == KEY);
  assign wr_ok    = we_i && unlocked;
  assign feed_o   = wr_ok && (addr_i == A_FEED);
  assign iclr_o   = wr_ok && (addr_i == A_ICLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      ctrl_q  <= '0;
      presc_q <= '0;
      ien_q   <= 1'b0;
    end else begin
      if (we_i && addr_i == A_KEY) key_q <= wdata_i;
      if (wr_ok && addr_i == A_CTRL)  ctrl_q  <= wdata_i[CTRL_W-1:0];
      if (wr_ok && addr_i == A_PRESC) presc_q <= wdata_i;
      if (wr_ok && addr_i == A_IEN)   ien_q   <= wdata_i[0];
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_tmo
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tmo_q[g] <= '0;
      else if (wr_ok && addr_i == ADDR_W'(A_TMO0 + g)) tmo_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = 32'(ctrl_q);
      A_PRESC: rdata_o = presc_q;
      A_KEY:   rdata_o = {31'b0, unlocked};
      A_IEN:   rdata_o = {31'b0, ien_q};
      A_STAT:  rdata_o = 32'({state_i, stage_i, int_raw_i});
      default:
        if (addr_i >= A_TMO0 && addr_i < ADDR_W'(A_TMO0 + NSTG))
          rdata_o = tmo_q[SW'(addr_i - A_TMO0)];
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign presc_o = presc_q;
  assign tmo_o   = tmo_q;
  assign ien_o   = ien_q;

  assert_locked_ctrl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && !unlocked) |=> $stable(ctrl_q));
  assert_locked_presc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_PRESC && !unlocked) |=> $stable(presc_q));
endmodule

// File: rtl/wdog_presc.sv
module wdog_presc (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        run_i,
  input  logic        clr_i,
  input  logic [31:0] presc_i,
  output logic        tick_o
);
  logic [31:0] cnt_q, lim;

  assign lim    = (presc_i == '0) ? '0 : presc_i - 32'd1;
  assign tick_o = en_i && run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !run_i)  cnt_q <= '0;
    else if (en_i)             cnt_q <= tick_o ? '0 : cnt_q + 32'd1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lim != '0 && !clr_i && $stable(presc_i)) |=> !tick_o);
  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i && run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  tick_i,
  input  logic                  feed_i,
  input  logic [2*NSTG-1:0]     act_i,
  input  logic [NSTG-1:0][31:0] tmo_i,
  input  logic                  pulse_busy_i,
  output logic                  fire_cpu_o,
  output logic                  fire_sys_o,
  output logic                  irq_set_o,
  output logic                  run_o,
  output logic [SW-1:0]         stage_o,
  output logic [1:0]            state_o
);
  localparam logic [SW-1:0] LAST = SW'(NSTG - 1);

  st_e           state_q;
  logic [SW-1:0] stage_q;
  logic [31:0]   cnt_q, lim;
  logic          en_q, expire;
  act_e          cur_act;

  assign cur_act    = act_e'(act_i[2*stage_q +: 2]);
  assign lim        = (tmo_i[stage_q] == '0) ? '0 : tmo_i[stage_q] - 32'd1;
  assign expire     = (state_q == ST_RUN) && tick_i && (cur_act != ACT_OFF) && (cnt_q >= lim);
  assign fire_cpu_o = expire && (cur_act == ACT_CPU);
  assign fire_sys_o = expire && (cur_act == ACT_SYS);
  assign irq_set_o  = expire && (cur_act == ACT_IRQ);
  assign run_o      = (state_q == ST_RUN);
  assign stage_o    = stage_q;
  assign state_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      stage_q <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      en_q <= en_i;
      if (feed_i) begin
        state_q <= ST_RUN;
        stage_q <= '0;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_RUN:
            if (en_i && cur_act == ACT_OFF) state_q <= ST_HOLD;
            else if (expire) begin
              cnt_q <= '0;
              if (cur_act != ACT_IRQ)  state_q <= ST_PULSE;
              else if (stage_q == LAST) state_q <= ST_HOLD;
              else                      stage_q <= stage_q + 1'b1;
            end else if (tick_i) cnt_q <= cnt_q + 32'd1;
          ST_HOLD:
            if (en_i && !en_q) begin
              state_q <= ST_RUN;
              stage_q <= '0;
              cnt_q   <= '0;
            end
          default:
            if (!pulse_busy_i) begin
              state_q <= ST_RUN;
              stage_q <= '0;
              cnt_q   <= '0;
            end
        endcase
      end
    end
  end

  assert_stage_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q != $past(stage_q)) |-> (stage_q == '0 || stage_q == $past(stage_q) + 1'b1));
  assert_pulse_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE && pulse_busy_i && !feed_i) |=> state_q == ST_PULSE);
  assert_hold_stays_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !feed_i && !(en_i && !en_q)) |=> (state_q == ST_HOLD && $stable(stage_q)));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned STEP = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic [2:0] len_i,
  output logic       pulse_o
);
  localparam int unsigned CW = $clog2(8 * STEP + 1);

  logic [CW-1:0] cnt_q, load;
  logic [CW-1:0] chk_hi_q, chk_len_q;

  assign load    = CW'((32'(len_i) + 32'd1) * STEP);
  assign pulse_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (fire_i)  cnt_q <= load;
    else if (pulse_o) cnt_q <= cnt_q - 1'b1;
  end

  // width checker: counts high cycles against the length captured at fire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_hi_q  <= '0;
      chk_len_q <= '0;
    end else if (fire_i) begin
      chk_hi_q  <= '0;
      chk_len_q <= load;
    end else if (pulse_o) chk_hi_q <= chk_hi_q + 1'b1;
  end

  assert_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> (chk_hi_q == chk_len_q));
endmodule

// File: rtl/wdog_stage_timer.sv
module wdog_stage_timer
  import wdog_pkg::*;
#(
  parameter logic [31:0] KEY      = 32'h5A17_C0DE,
  parameter int unsigned LEN_STEP = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  ctrl_t                 ctrl;
  logic [31:0]           presc;
  logic [NSTG-1:0][31:0] tmo;
  logic                  ien, feed, iclr, tick, run;
  logic                  fire_cpu, fire_sys, irq_set, int_raw_q;
  logic [SW-1:0]         stage;
  logic [1:0]            state;

  wdog_regs #(.KEY(KEY)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ctrl_o(ctrl), .presc_o(presc), .tmo_o(tmo), .ien_o(ien),
    .feed_o(feed), .iclr_o(iclr),
    .int_raw_i(int_raw_q), .stage_i(stage), .state_i(state)
  );

  wdog_presc u_presc (
    .clk_i, .rst_ni, .en_i(ctrl.en), .run_i(run), .clr_i(feed),
    .presc_i(presc), .tick_o(tick)
  );

  wdog_stage u_stage (
    .clk_i, .rst_ni, .en_i(ctrl.en), .tick_i(tick), .feed_i(feed),
    .act_i(ctrl.act), .tmo_i(tmo), .pulse_busy_i(cpu_rst_o || sys_rst_o),
    .fire_cpu_o(fire_cpu), .fire_sys_o(fire_sys), .irq_set_o(irq_set),
    .run_o(run), .stage_o(stage), .state_o(state)
  );

  wdog_pulse #(.STEP(LEN_STEP)) u_cpu_pulse (
    .clk_i, .rst_ni, .fire_i(fire_cpu), .len_i(ctrl.cpu_len), .pulse_o(cpu_rst_o)
  );

  wdog_pulse #(.STEP(LEN_STEP)) u_sys_pulse (
    .clk_i, .rst_ni, .fire_i(fire_sys), .len_i(ctrl.sys_len), .pulse_o(sys_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              int_raw_q <= 1'b0;
    else if (irq_set)         int_raw_q <= 1'b1;
    else if (iclr || feed)    int_raw_q <= 1'b0;
  end

  assign irq_o = int_raw_q && ctrl.lvl_en && ien;

  assert_irq_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set |=> int_raw_q);
  assert_irq_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((iclr || feed) && !irq_set) |=> !int_raw_q);
  assert_one_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_rst_o && sys_rst_o));
  assert_feed_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed |=> (stage == '0 && state == 2'd0));
endmodule

// File: tb/sim_wdog_stage_timer.sv
`timescale 1ns/1ps
module sim_wdog_stage_timer;
  localparam logic [31:0] KEY = 32'h5A17_C0DE;
  localparam int STEP = 32;

  logic clk = 0, rst_n = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, cpu_rst, sys_rst;
  int cyc = 0, total = 0, bad = 0;
  logic done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_stage_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
  );

  function automatic int eff(input int v); return (v == 0) ? 1 : v; endfunction
  function automatic logic [31:0] mk_ctrl(input int lvl, a0, a1, a2, a3, cl, sl);
    return 32'({3'(sl), 3'(cl), 2'(a3), 2'(a2), 2'(a1), 2'(a0), 1'(lvl), 1'b0});
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic sig(input int s);
    return (s == 0) ? irq : (s == 1) ? cpu_rst : sys_rst;
  endfunction

  task automatic wait_sig(input int s, input int maxc, output int t);
    t = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (sig(s)) begin t = cyc; break; end
    end
  endtask

  task automatic width(input int s, output int w);
    w = 0;
    while (sig(s) && w < 2000) begin w++; @(negedge clk); end
  endtask

  // disable, program, clear, feed, enable; returns edge index of the start
  task automatic cfg(input logic [31:0] c, input int p, t0, t1, t2, t3, output int start);
    wr(4'h0, c & ~32'd1);
    wr(4'h1, 32'(p));
    wr(4'h2, 32'(t0)); wr(4'h3, 32'(t1)); wr(4'h4, 32'(t2)); wr(4'h5, 32'(t3));
    wr(4'h9, 0);
    wr(4'h6, 0);
    wr(4'h0, c | 32'd1);
    start = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int st, t, t2, w, p, a, b, cl, d0, n0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(4'h0, d); chk("R4 ctrl reset", d, 0);
    rd(4'hA, d); chk("R11 status reset", d, 0);
    chk("R5 irq reset", irq, 0);
    chk("R8 resets idle", {cpu_rst, sys_rst}, 0);

    // R1 lock behaviour
    rd(4'h7, d); chk("R1 locked", d, 0);
    wr(4'h0, 32'hFFFF); rd(4'h0, d); chk("R1 ctrl write ignored", d, 0);
    wr(4'h2, 32'd5);    rd(4'h2, d); chk("R1 timeout write ignored", d, 0);
    wr(4'h7, KEY); rd(4'h7, d); chk("R1 unlocked", d, 1);
    wr(4'h2, 32'd5); rd(4'h2, d); chk("R1 R3 timeout write", d, 5);
    wr(4'h7, 32'h1); wr(4'h1, 32'd9); rd(4'h1, d); chk("R1 relocked", d, 0);
    wr(4'h7, KEY);
    wr(4'h8, 1);

    // interrupt then CPU reset
    cfg(mk_ctrl(1, 1, 2, 0, 0, 1, 0), 3, 4, 5, 1, 1, st);
    wait_sig(0, 500, t); chk("R2 R3 R5 irq time", t - st, 12);
    rd(4'hA, d); chk("R11 status after stage0", d, 3);
    wr(4'h9, 0); @(negedge clk); chk("R5 irq cleared", irq, 0);
    wait_sig(1, 500, t); chk("R4 R3 cpu reset time", t - st, 27);
    chk("R8 no sys reset", sys_rst, 0);
    width(1, w); chk("R8 cpu width", w, 2 * STEP);
    wait_sig(0, 500, t2); chk("R9 restart after pulse", t2 - t, 2 * STEP + 1 + 12);

    // masking and halt on none action
    cfg(mk_ctrl(0, 1, 0, 0, 0, 0, 0), 2, 3, 3, 1, 1, st);
    repeat (12) @(negedge clk);
    chk("R5 irq masked", irq, 0);
    rd(4'hA, d); chk("R10 R11 halted in stage1", d, 32'hB);
    repeat (40) @(negedge clk);
    chk("R10 no reset while halted", {cpu_rst, sys_rst}, 0);
    wr(4'h6, 0); rd(4'hA, d); chk("R6 feed restarts", d, 0);
    wr(4'h0, mk_ctrl(1, 1, 0, 0, 0, 0, 0) | 1);
    wr(4'h8, 0); @(negedge clk);
    chk("R5 irq gated by enable register", irq, 0);
    wr(4'h8, 1);

    // enable freeze
    cfg(mk_ctrl(1, 1, 0, 0, 0, 0, 0), 2, 10, 1, 1, 1, st);
    repeat (7) @(negedge clk);
    wr(4'h0, mk_ctrl(1, 1, 0, 0, 0, 0, 0)); d0 = cyc;
    repeat (30) @(negedge clk);
    chk("R7 frozen no irq", irq, 0);
    wr(4'h0, mk_ctrl(1, 1, 0, 0, 0, 0, 0) | 1); n0 = cyc;
    wait_sig(0, 500, t); chk("R7 freeze delay", t - st, 20 + (n0 - d0));

    // feed postpones expiry
    cfg(mk_ctrl(1, 1, 0, 0, 0, 0, 0), 1, 20, 1, 1, 1, st);
    repeat (13) @(negedge clk);
    wr(4'h6, 0); d0 = cyc;
    wait_sig(0, 500, t); chk("R6 feed delays expiry", t - d0, 20);

    // system reset at stage 3 after interrupts
    cfg(mk_ctrl(1, 1, 1, 1, 3, 0, 2), 1, 2, 2, 2, 2, st);
    wait_sig(2, 500, t); chk("R3 R4 sys reset at stage3", t - st, 8);
    chk("R8 cpu quiet", cpu_rst, 0);
    width(2, w); chk("R8 sys width", w, 3 * STEP);

    // none at stage 0
    cfg(mk_ctrl(1, 0, 1, 0, 0, 0, 0), 1, 1, 1, 1, 1, st);
    repeat (30) @(negedge clk);
    chk("R10 no irq", irq, 0);
    rd(4'hA, d); chk("R10 R11 halted stage0", d, 32'h8);

    // zero divider and zero timeout
    cfg(mk_ctrl(1, 1, 0, 0, 0, 0, 0), 0, 0, 1, 1, 1, st);
    wait_sig(0, 50, t); chk("R2 R3 zero acts as one", t - st, 1);

    // random
    for (int i = 0; i < 8; i++) begin
      p = int'($urandom_range(0, 3)); a = int'($urandom_range(1, 6));
      b = int'($urandom_range(1, 6)); cl = int'($urandom_range(0, 3));
      cfg(mk_ctrl(1, 1, 2, 0, 0, cl, 0), p, a, b, 1, 1, st);
      wait_sig(0, 500, t); chk("R3 R5 random irq", t - st, eff(p) * a);
      wait_sig(1, 500, t); chk("R3 random cpu", t - st, eff(p) * (a + b));
      width(1, w); chk("R8 random width", w, (cl + 1) * STEP);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule